// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter clocked entirely by an external serial clock. While the active-low select is held low, it watches the data input for a leading 1. It takes that 1 and the seven bits after it as a control byte. From the byte it derives the analog multiplexer routing: which channel feeds the positive side, and whether the negative side is the common pin or the partner channel of a differential pair. It opens and closes the track/hold switch at fixed serial-clock edges. It then walks a successive-approximation register against a one-bit comparator input and shifts the result out on a data pin that is enabled only while selected. A strobe pulse marks the approach of the first result bit.

The serial lines are brought into the system clock domain through a configurable synchronizer, and all sequencing is done on the detected serial-clock edges. "High impedance" is represented by separate output-enable ports for the data pin and the strobe pin, which the pad ring turns into tri-state drivers. The trial code is presented on `dac_code` for the capacitive DAC; the comparator answer returns on `cmp_hi`.

Top module: `adc_serial_seq`

## Requirements
- R1: Data bits are taken on rising serial-clock edges only while select is low. Zeros received before the first 1 are discarded, and that 1 becomes bit 7 (MSB, start) of the control byte.
- R2: Control byte fields: bit 6 = A, bit 5 = B, bit 4 = C, bit 3 = single-ended flag, bits 2..0 have no routing function. With the flag at 1, `pos_sel` = {B,C,A} and `neg_com` = 1.
- R3: With the flag at 0, the pair {B,C} is routed: `pos_sel` = {B,C,A}, `neg_sel` = {B,C,~A}, `neg_com` = 0.
- R4: Counting falling edges from the one after the start bit as number 1, `trk` is high from falling edge 6 until falling edge 8. At falling edge 8 `trk` drops and `hold_neg` rises, in the same system-clock cycle.
- R5: `hold_neg` returns low at falling edge 16, when the conversion ends.
- R6: The conversion takes falling edges 9 to 16, one bit each, MSB first. A trial bit is kept when `cmp_hi` is 1 and cleared otherwise. After edge 16, `dac_code` holds the result; with `cmp_hi` = (input >= `dac_code`) that equals the input value.
- R7: `strobe` is high from falling edge 14 to falling edge 16, which is two serial-clock periods, and is low whenever the MSB is being driven.
- R8: The result is driven on `dout` MSB first, changing on falling edges 16 to 23; `dout` is 0 before edge 16 and after the LSB until select rises.
- R9: `dout_oe` and `strobe_oe` are high exactly while the synchronized select is low.
- R10: Raising select at any point aborts the transaction: `trk`, `hold_neg` and `strobe` clear, both enables drop, and the next transaction starts from start-bit search.
- R11: Control byte bits 2..0 do not change the routing or the conversion result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial control data |
| cmp_hi | input | 1 | Comparator: sampled input at or above DAC level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Drive enable for `dout` |
| strobe | output | 1 | Pulse ahead of the result MSB |
| strobe_oe | output | 1 | Drive enable for `strobe` |
| trk | output | 1 | Track/hold switch closed (tracking) |
| hold_neg | output | 1 | Hold node switched to the negative input |
| pos_sel | output | 3 | Positive input channel |
| neg_sel | output | 3 | Negative input channel (differential) |
| neg_com | output | 1 | Negative input is the common pin |
| dac_code | output | RES_BITS | Trial/result code to the DAC |

## Verification
The hardest states to reach are those tied to a specific falling-edge number: the two-edge tracking window, the strobe window and the handover from hold to result. The start bit can also arrive after an arbitrary number of leading zeros. The bench drives the serial lines bit by bit, checking every output after each falling edge against an edge index counted from the start bit. It varies the number of leading zeros, sweeps all eight select codes in both input modes with changing channel voltages, and raises select in the middle of a conversion before running a clean transaction.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int CTL_BITS = 8;
   localparam int CH_W     = 3;
   localparam int FLD_A    = 6;
   localparam int FLD_B    = 5;
   localparam int FLD_C    = 4;
   localparam int FLD_SGL  = 3;

   typedef struct packed {
      logic [CH_W-1:0] pos;
      logic [CH_W-1:0] neg;
      logic            to_com;
   } route_t;

   function automatic route_t route_decode(input logic [CTL_BITS-1:0] b);
      route_t r;
      r.pos    = {b[FLD_B], b[FLD_C], b[FLD_A]};
      r.neg    = {b[FLD_B], b[FLD_C], ~b[FLD_A]};
      r.to_com = b[FLD_SGL];
      return r;
   endfunction
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic cs_n_i,
   input  logic din_i,
   output logic active,
   output logic rise,
   output logic fall,
   output logic din_s
);
   logic [2:0] raw, syn;
   logic       sclk_prev;

   assign raw = {cs_n_i, sclk_i, din_i};

   generate
      if (STAGES == 0) begin : g_direct
         assign syn = raw;
      end else begin : g_chain
         logic [2:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= 3'b100;
            end else begin
               st[0] <= raw;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign syn = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= syn[1];
   end

   assign active = ~syn[2];
   assign rise   = active &  syn[1] & ~sclk_prev;
   assign fall   = active & ~syn[1] &  sclk_prev;
   assign din_s  = syn[0];
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
   import adc_seq_pkg::*;
#(
   parameter int RES_BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic            rise,
   input  logic            fall,
   input  logic            din_s,
   output logic            trk,
   output logic            hold_neg,
   output logic            strobe,
   output route_t          route,
   output logic            conv_load,
   output logic            conv_step,
   output logic            conv_last
);
   localparam int END_F = CTL_BITS + RES_BITS;
   localparam int CW    = $clog2(END_F + 1);
   localparam int BW    = $clog2(CTL_BITS + 1);
   localparam logic [CW-1:0] F_TRK  = CW'(CTL_BITS - 2);
   localparam logic [CW-1:0] F_HOLD = CW'(CTL_BITS);
   localparam logic [CW-1:0] F_STB  = CW'(END_F - 2);
   localparam logic [CW-1:0] F_END  = CW'(END_F);
   localparam logic [BW-1:0] B_FULL = BW'(CTL_BITS);

   logic                started;
   logic [BW-1:0]       bcnt;
   logic [CTL_BITS-1:0] sh;
   logic [CW-1:0]       fcnt, fnext;
   logic                fadv;

   assign fadv      = fall & started & (fcnt != F_END);
   assign fnext     = fcnt + 1'b1;
   assign conv_load = fadv & (fnext == F_HOLD);
   assign conv_step = fadv & (fnext >  F_HOLD);
   assign conv_last = fadv & (fnext == F_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         bcnt     <= '0;
         sh       <= '0;
         fcnt     <= '0;
         trk      <= 1'b0;
         hold_neg <= 1'b0;
         strobe   <= 1'b0;
         route    <= '0;
      end else if (!active) begin
         started  <= 1'b0;
         bcnt     <= '0;
         sh       <= '0;
         fcnt     <= '0;
         trk      <= 1'b0;
         hold_neg <= 1'b0;
         strobe   <= 1'b0;
         route    <= '0;
      end else begin
         if (rise) begin
            if (!started) begin
               if (din_s) begin
                  started <= 1'b1;
                  bcnt    <= BW'(1);
                  sh      <= {sh[CTL_BITS-2:0], 1'b1};
               end
            end else if (bcnt != B_FULL) begin
               bcnt <= bcnt + 1'b1;
               sh   <= {sh[CTL_BITS-2:0], din_s};
            end
         end
         if (fadv) begin
            fcnt <= fnext;
            if (fnext == F_TRK) begin
               trk   <= 1'b1;
               route <= route_decode({sh[CTL_BITS-3:0], 2'b00});
            end
            if (fnext == F_HOLD) begin
               trk      <= 1'b0;
               hold_neg <= 1'b1;
            end
            if (fnext == F_STB) strobe <= 1'b1;
            if (fnext == F_END) begin
               strobe   <= 1'b0;
               hold_neg <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
   parameter int RES_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                load,
   input  logic                step,
   input  logic                cmp_hi,
   output logic [RES_BITS-1:0] code,
   output logic [RES_BITS-1:0] code_next
);
   localparam int IW = $clog2(RES_BITS);
   localparam logic [IW-1:0] TOP_IDX = IW'(RES_BITS - 1);

   logic [IW-1:0] idx;

   always_comb begin
      code_next = code;
      if (!cmp_hi) code_next[idx] = 1'b0;
      if (idx != '0) code_next[idx - 1'b1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
         idx  <= '0;
      end else if (!active) begin
         code <= '0;
         idx  <= '0;
      end else if (load) begin
         code <= {1'b1, {(RES_BITS-1){1'b0}}};
         idx  <= TOP_IDX;
      end else if (step) begin
         code <= code_next;
         if (idx != '0) idx <= idx - 1'b1;
      end
   end
endmodule

// File: rtl/adc_seq_out.sv
module adc_seq_out #(
   parameter int RES_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                active,
   input  logic                fall,
   input  logic                load,
   input  logic [RES_BITS-1:0] value,
   output logic                dout
);
   logic [RES_BITS-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh <= '0;
      else if (!active) sh <= '0;
      else if (load)    sh <= value;
      else if (fall)    sh <= {sh[RES_BITS-2:0], 1'b0};
   end

   assign dout = sh[RES_BITS-1];
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
   import adc_seq_pkg::*;
#(
   parameter int RES_BITS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk,
   input  logic                cs_n,
   input  logic                din,
   input  logic                cmp_hi,
   output logic                dout,
   output logic                dout_oe,
   output logic                strobe,
   output logic                strobe_oe,
   output logic                trk,
   output logic                hold_neg,
   output logic [CH_W-1:0]     pos_sel,
   output logic [CH_W-1:0]     neg_sel,
   output logic                neg_com,
   output logic [RES_BITS-1:0] dac_code
);
   generate
      if (RES_BITS < 3 || RES_BITS > 16) begin : g_bad_res
         $error("adc_serial_seq: RES_BITS must lie in 3..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_serial_seq: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic   active, rise, fall, din_s;
   logic   conv_load, conv_step, conv_last;
   route_t route;
   logic [RES_BITS-1:0] code_next;

   adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
      .active(active), .rise(rise), .fall(fall), .din_s(din_s)
   );

   adc_seq_ctl #(.RES_BITS(RES_BITS)) u_ctl (
      .clk(clk), .rst_n(rst_n), .active(active), .rise(rise), .fall(fall),
      .din_s(din_s), .trk(trk), .hold_neg(hold_neg), .strobe(strobe),
      .route(route), .conv_load(conv_load), .conv_step(conv_step),
      .conv_last(conv_last)
   );

   adc_seq_sar #(.RES_BITS(RES_BITS)) u_sar (
      .clk(clk), .rst_n(rst_n), .active(active), .load(conv_load),
      .step(conv_step), .cmp_hi(cmp_hi), .code(dac_code), .code_next(code_next)
   );

   adc_seq_out #(.RES_BITS(RES_BITS)) u_out (
      .clk(clk), .rst_n(rst_n), .active(active), .fall(fall),
      .load(conv_last), .value(code_next), .dout(dout)
   );

   assign dout_oe   = active;
   assign strobe_oe = active;
   assign pos_sel   = route.pos;
   assign neg_sel   = route.neg;
   assign neg_com   = route.to_com;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic dout,
   input logic dout_oe,
   input logic strobe,
   input logic trk,
   input logic hold_neg
);
   // R4
   trk_hold_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(trk && hold_neg));

   // R4
   hold_after_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_neg) |-> $fell(trk));

   // R7
   strobe_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe) |-> hold_neg);

   // R7
   strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(strobe) && dout_oe) |-> $fell(hold_neg));

   // R8
   quiet_under_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && dout_oe) |-> !dout);

   // R10
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_oe && $past(!dout_oe)) |-> (!trk && !hold_neg && !strobe));
endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .dout(dout), .dout_oe(dout_oe),
   .strobe(strobe), .trk(trk), .hold_neg(hold_neg)
);

// File: tb/tb_adc_serial_seq.sv
module tb_adc_serial_seq;
   localparam int H = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
   logic cmp_hi;
   logic dout, dout_oe, strobe, strobe_oe, trk, hold_neg, neg_com;
   logic [2:0] pos_sel, neg_sel;
   logic [7:0] dac_code;

   int n_chk = 0, n_err = 0;
   int vin_model = 0;
   int ch [8];
   int com_v = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   assign cmp_hi = (vin_model >= int'(dac_code));

   adc_serial_seq dut (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
      .cmp_hi(cmp_hi), .dout(dout), .dout_oe(dout_oe), .strobe(strobe),
      .strobe_oe(strobe_oe), .trk(trk), .hold_neg(hold_neg),
      .pos_sel(pos_sel), .neg_sel(neg_sel), .neg_com(neg_com),
      .dac_code(dac_code)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Runs one transaction; abort_at > 0 raises select after that falling edge.
   task automatic xfer(input bit [2:0] sel, input bit sgl, input bit [2:0] mode,
                       input int lead, input int abort_at);
      bit [7:0] ctl;
      int pos, neg, v;
      ctl = {1'b1, sel[2], sel[1], sel[0], sgl, mode};
      pos = {sel[1], sel[0], sel[2]};
      neg = {sel[1], sel[0], ~sel[2]};
      v = ch[pos] - (sgl ? com_v : ch[neg]);
      if (v < 0) v = 0;
      vin_model = v;
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < lead + 26; i++) begin
         int k;
         k = i - lead + 1;
         din = (k >= 1 && k <= 8) ? ctl[8-k] : 1'b0;
         repeat (H) @(negedge clk);
         sclk = 1'b1;
         repeat (H) @(negedge clk);
         sclk = 1'b0;
         repeat (H-1) @(negedge clk);
         if (abort_at > 0 && k == abort_at) begin
            cs_n = 1'b1;
            repeat (6) @(negedge clk);
            chk("R10", "dout_oe", dout_oe, 0);
            chk("R10", "strobe_oe", strobe_oe, 0);
            chk("R10", "trk", trk, 0);
            chk("R10", "hold_neg", hold_neg, 0);
            chk("R10", "strobe", strobe, 0);
            return;
         end
         chk("R9", "dout_oe", dout_oe, 1);
         chk("R9", "strobe_oe", strobe_oe, 1);
         chk(k <= 0 ? "R1" : "R4", "trk", trk, int'(k >= 6 && k < 8));
         chk(k >= 16 ? "R5" : "R4", "hold_neg", hold_neg, int'(k >= 8 && k < 16));
         chk("R7", "strobe", strobe, int'(k >= 14 && k < 16));
         chk("R8", "dout", dout, (k >= 16 && k <= 23) ? ((v >> (23 - k)) & 1) : 0);
         if (k == 8) begin
            chk(sgl ? "R2" : "R3", "pos_sel", pos_sel, pos);
            chk(sgl ? "R2" : "R3", "neg_com", neg_com, sgl);
            if (!sgl) chk("R3", "neg_sel", neg_sel, neg);
         end
         if (k == 16)
            chk(mode != 0 ? "R11" : "R6", "dac_code", dac_code, v);
         @(negedge clk);
      end
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R9", "dout_oe idle", dout_oe, 0);
      chk("R9", "strobe_oe idle", strobe_oe, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R9", "reset dout_oe", dout_oe, 0);
      chk("R4", "reset trk", trk, 0);
      chk("R4", "reset hold_neg", hold_neg, 0);
      chk("R7", "reset strobe", strobe, 0);

      for (int it = 0; it < 2; it++) begin
         for (int i = 0; i < 8; i++) ch[i] = (i * 53 + it * 91 + 17) % 256;
         com_v = it * 23 + 3;
         for (int s = 0; s < 2; s++)
            for (int sel = 0; sel < 8; sel++)
               xfer(3'(sel), s[0], 3'((sel * 3 + it) % 8), sel % 3, 0);
      end

      // Boundary: full scale and zero difference
      for (int i = 0; i < 8; i++) ch[i] = 0;
      ch[0] = 255; ch[1] = 255; com_v = 0;
      xfer(3'b000, 1'b1, 3'b000, 0, 0);
      xfer(3'b000, 1'b0, 3'b000, 1, 0);

      // R10: abort mid-conversion, then a clean transaction
      ch[2] = 170; com_v = 0;
      xfer(3'b001, 1'b1, 3'b000, 2, 11);
      xfer(3'b001, 1'b1, 3'b000, 0, 0);
      xfer(3'b001, 1'b1, 3'b000, 1, 15);
      ch[3] = 85;
      xfer(3'b101, 1'b1, 3'b111, 0, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule